// File: doc/BRIEF.md
# ADC Track-and-Convert Sequencer

This block sequences a 10-bit successive-approximation converter. It decides when the sample-and-hold follows the input, when a conversion starts and when the converter is busy. It resolves one result bit per SAR clock step, most significant bit first. Each bit decision comes from a comparator input. The analog comparator, the DAC, multiplexer control and settling-time checks live outside the block.

A 2-bit field selects the start source: one of two timer overflow strobes, a software start write, or the rising edge of an external start pin. A mode bit selects one of two tracking policies. In continuous mode the input is tracked whenever no conversion runs. In low-power mode tracking is off while idle. With a timer or software start, a fixed three-step tracking window opens first. With the external pin as source, tracking follows the pin while it is low and the conversion begins on its rising edge. A sleep request shuts tracking off and aborts any conversion.

All sequencing advances only on system clock edges where the SAR clock enable is high. Start events are accepted on any system clock edge. The result leaves with a one-cycle `done` strobe that acts as its valid flag. There is no ready input: a consumer that cannot take the result must copy it while `done` is high, because the sequencer never stalls.

Top module: `adc_seq_top`

## Requirements
- R1: With `lp_mode` = 0 and `sleep_req` = 0, `track_en` is 1 in every cycle where `conv_en` is 0, and 0 in every cycle where `conv_en` is 1.
- R2: With `lp_mode` = 1 and a timer or software source, `track_en` is 0 while idle. An accepted start raises `busy` with `track_en` = 1 for exactly 3 edges where `sar_ce` = 1. After those, the conversion begins.
- R3: With `lp_mode` = 1 and `trig_sel` = 11, `track_en` while idle is the inverse of the pin after a two-flop synchronizer. A pin that rises before edge k is accepted at edge k+2. The conversion then starts at once, with no tracking window.
- R4: `trig_sel` picks the start source: 00 = `tmr_a_ovf`, 01 = `tmr_b_ovf`, 10 = `sw_start`, 11 = rising edge of `ext_start`. Strobes on unselected sources start nothing.
- R5: While `sleep_req` is 1, `track_en` is 0, `busy` is 0 from the next edge, starts are refused, and an aborted conversion produces no `done`.
- R6: A conversion outputs `conv_en` = 1 with `bit_idx` running 9 down to 0. At the edge where `bit_idx` = i and `sar_ce` = 1, `result[i]` takes `cmp_in`.
- R7: `busy` rises at the edge that accepts a start. It falls at the edge that takes the bit-0 decision. At that same edge `done` rises for exactly one clock, with `result` holding all 10 decisions.
- R8: Start events that arrive while `busy` is 1 are dropped and are not queued. After `done`, `busy` stays 0 until a new start arrives.
- R9: The tracking window and the bit steps advance only on edges with `sar_ce` = 1. A conversion takes exactly 10 such edges, and start acceptance ignores `sar_ce`.
- R10: After reset, and after `sleep_req` falls, the block is idle. `track_en` is then 1 with `lp_mode` = 0 and 0 with `lp_mode` = 1, unless the R3 pin rule applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sar_ce | input | 1 | SAR clock enable, one step per high cycle |
| trig_sel | input | 2 | Start source select |
| lp_mode | input | 1 | 0 = continuous tracking, 1 = low-power tracking |
| tmr_a_ovf | input | 1 | First timer overflow strobe |
| tmr_b_ovf | input | 1 | Second timer overflow strobe |
| sw_start | input | 1 | Software start write strobe |
| ext_start | input | 1 | External start pin, asynchronous |
| sleep_req | input | 1 | Sleep/standby request |
| cmp_in | input | 1 | Comparator bit decision |
| track_en | output | 1 | Sample-and-hold tracking enable |
| conv_en | output | 1 | Conversion in progress |
| bit_idx | output | 4 | Bit currently being resolved |
| busy | output | 1 | Converter busy |
| done | output | 1 | One-cycle result valid strobe |
| result | output | 10 | Conversion result |

## Verification
The hardest case to reach is a start strobe that lands during a conversion whose SAR clock enable is stalled at random, and in particular one on the same edge that takes the last bit decision. Only the absence of a second conversion after `done` shows that it was dropped. The stimulus runs conversions with a random `sar_ce` duty and fires extra strobes on the selected source in random cycles while `busy` is high. It then watches `busy` after `done`. Sleep is asserted mid-conversion to check the abort path, and the pin source is driven low and then high in both modes to check the synchronizer latency.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_e;

  localparam logic [1:0] SRC_TMR_A = 2'b00;
  localparam logic [1:0] SRC_TMR_B = 2'b01;
  localparam logic [1:0] SRC_SW    = 2'b10;
  localparam logic [1:0] SRC_PIN   = 2'b11;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] trig_sel,
  input  logic       tmr_a_ovf,
  input  logic       tmr_b_ovf,
  input  logic       sw_start,
  input  logic       ext_start,
  output logic       start_ev,
  output logic       pin_level
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         pin_prev;
  logic         pin_rise;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= ext_start;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= 1'b0;
    else pin_prev <= sync_q[TOP];
  end

  assign pin_rise  = sync_q[TOP] & ~pin_prev;
  assign pin_level = sync_q[TOP];

  always_comb begin
    unique case (trig_sel)
      SRC_TMR_A: start_ev = tmr_a_ovf;
      SRC_TMR_B: start_ev = tmr_b_ovf;
      SRC_SW:    start_ev = sw_start;
      default:   start_ev = pin_rise;
    endcase
  end

  // R4
  sw_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && trig_sel == SRC_SW) |-> sw_start);

  // R3
  pin_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && trig_sel == SRC_PIN) |-> !pin_prev);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int TRACK_CLKS = 3,
  localparam int IDX_W     = $clog2(RES_W),
  localparam int CNT_W     = $clog2(TRACK_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sar_ce,
  input  logic             lp_mode,
  input  logic             pin_src,
  input  logic             pin_level,
  input  logic             start_ev,
  input  logic             sleep_req,
  input  logic             cmp_in,
  output logic             track_en,
  output logic             conv_en,
  output logic [IDX_W-1:0] bit_idx,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(RES_W - 1);
  localparam logic [CNT_W-1:0] LAST_TRK = CNT_W'(TRACK_CLKS - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] trk_cnt;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] sar_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      trk_cnt <= '0;
      idx_q   <= '0;
      sar_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sleep_req) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (start_ev) begin
            if (lp_mode && !pin_src) begin
              state   <= ST_TRACK;
              trk_cnt <= '0;
            end else begin
              state <= ST_CONV;
              idx_q <= MSB_IDX;
              sar_q <= '0;
            end
          end
          ST_TRACK: if (sar_ce) begin
            if (trk_cnt == LAST_TRK) begin
              state <= ST_CONV;
              idx_q <= MSB_IDX;
              sar_q <= '0;
            end else begin
              trk_cnt <= trk_cnt + 1'b1;
            end
          end
          ST_CONV: if (sar_ce) begin
            sar_q[idx_q] <= cmp_in;
            if (idx_q == '0) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    if (sleep_req)    track_en = 1'b0;
    else if (lp_mode) track_en = (state == ST_TRACK) ||
                                 (state == ST_IDLE && pin_src && !pin_level);
    else              track_en = (state != ST_CONV);
  end

  assign conv_en = (state == ST_CONV);
  assign bit_idx = idx_q;
  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign result  = sar_q;

  // R1
  conv_track_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |-> !track_en);

  // R5
  sleep_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (!busy && !done));

  // R6
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && sar_ce && !sleep_req && bit_idx != '0) |=>
      (conv_en && bit_idx == $past(bit_idx) - 1'b1));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && !sar_ce && !sleep_req) |=> (conv_en && $stable(bit_idx)));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int TRACK_CLKS  = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sar_ce,
  input  logic [1:0]       trig_sel,
  input  logic             lp_mode,
  input  logic             tmr_a_ovf,
  input  logic             tmr_b_ovf,
  input  logic             sw_start,
  input  logic             ext_start,
  input  logic             sleep_req,
  input  logic             cmp_in,
  output logic             track_en,
  output logic             conv_en,
  output logic [IDX_W-1:0] bit_idx,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);
  logic start_ev;
  logic pin_level;

  adc_seq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_sel  (trig_sel),
    .tmr_a_ovf (tmr_a_ovf),
    .tmr_b_ovf (tmr_b_ovf),
    .sw_start  (sw_start),
    .ext_start (ext_start),
    .start_ev  (start_ev),
    .pin_level (pin_level)
  );

  adc_seq_ctrl #(.RES_W(RES_W), .TRACK_CLKS(TRACK_CLKS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sar_ce    (sar_ce),
    .lp_mode   (lp_mode),
    .pin_src   (trig_sel == SRC_PIN),
    .pin_level (pin_level),
    .start_ev  (start_ev),
    .sleep_req (sleep_req),
    .cmp_in    (cmp_in),
    .track_en  (track_en),
    .conv_en   (conv_en),
    .bit_idx   (bit_idx),
    .busy      (busy),
    .done      (done),
    .result    (result)
  );
endmodule

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sar_ce = 1'b1;
  logic [1:0] trig_sel = 2'b10;
  logic       lp_mode = 1'b0;
  logic       tmr_a_ovf = 1'b0, tmr_b_ovf = 1'b0, sw_start = 1'b0;
  logic       ext_start = 1'b0, sleep_req = 1'b0, cmp_in = 1'b0;
  logic       track_en, conv_en, busy, done;
  logic [3:0] bit_idx;
  logic [9:0] result;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  adc_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .sar_ce(sar_ce), .trig_sel(trig_sel),
    .lp_mode(lp_mode), .tmr_a_ovf(tmr_a_ovf), .tmr_b_ovf(tmr_b_ovf),
    .sw_start(sw_start), .ext_start(ext_start), .sleep_req(sleep_req),
    .cmp_in(cmp_in), .track_en(track_en), .conv_en(conv_en),
    .bit_idx(bit_idx), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit idle_track(input bit lp, input logic [1:0] sel, input bit pin);
    if (!lp) return 1'b1;
    return (sel == 2'b11) && !pin;
  endfunction

  function automatic int window_len(input bit lp, input logic [1:0] sel);
    return (lp && sel != 2'b11) ? 3 : 0;
  endfunction

  task automatic pulse_src(input logic [1:0] sel, input bit v);
    tmr_a_ovf = v && sel == 2'b00;
    tmr_b_ovf = v && sel == 2'b01;
    sw_start  = v && sel == 2'b10;
  endtask

  task automatic fire(input logic [1:0] sel);
    if (sel == 2'b11) begin
      ext_start = 1'b0;
      repeat (4) @(negedge clk);
      chk(track_en == idle_track(lp_mode, sel, 1'b0), "R3", track_en, idle_track(lp_mode, sel, 1'b0));
      ext_start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(busy == 1'b0, "R3", busy, 0);
      @(negedge clk);
    end else begin
      chk(track_en == idle_track(lp_mode, sel, 1'b0), "R10", track_en, idle_track(lp_mode, sel, 1'b0));
      pulse_src(sel, 1'b1);
      @(negedge clk);
      pulse_src(sel, 1'b0);
    end
    chk(busy == 1'b1, "R7", busy, 1);
  endtask

  task automatic convert(input logic [1:0] sel, input bit lp, input bit noisy, input int ce_pct);
    int tr = 0, cv = 0, nexp = 9;
    logic [9:0] expv = '0;
    bit fin = 0;
    trig_sel = sel;
    lp_mode  = lp;
    @(negedge clk);
    fire(sel);
    for (int c = 0; c < 3000 && !fin; c++) begin
      sar_ce = ($urandom_range(0, 99) < ce_pct);
      cmp_in = $urandom_range(0, 1);
      pulse_src(sel, noisy && sel != 2'b11 && busy && $urandom_range(0, 3) == 0);
      if (busy) chk(track_en == !conv_en, lp ? "R2" : "R1", track_en, !conv_en);
      if (conv_en && sar_ce) begin
        chk(bit_idx == nexp, "R6", bit_idx, nexp);
        expv[bit_idx] = cmp_in;
        nexp--;
        cv++;
      end else if (busy && !conv_en && sar_ce) begin
        tr++;
      end
      @(negedge clk);
      if (done) fin = 1;
    end
    pulse_src(sel, 1'b0);
    sar_ce = 1'b1;
    chk(fin, "R7", fin, 1);
    chk(busy == 1'b0, "R7", busy, 0);
    chk(result == expv, "R6", result, expv);
    chk(tr == window_len(lp, sel), lp && sel == 2'b11 ? "R3" : "R2", tr, window_len(lp, sel));
    chk(cv == 10, "R9", cv, 10);
    @(negedge clk);
    chk(done == 1'b0, "R7", done, 0);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R8", busy, 0);
    chk(track_en == idle_track(lp, sel, ext_start), "R10", track_en, idle_track(lp, sel, ext_start));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && conv_en == 0, "R10", busy, 0);
    chk(track_en == 1'b1, "R10", track_en, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(track_en == 1'b1, "R1", track_en, 1);

    for (int s = 0; s < 4; s++) convert(2'(s), 1'b0, 1'b0, 100);
    for (int s = 0; s < 4; s++) convert(2'(s), 1'b1, 1'b0, 100);

    // R4: unselected sources start nothing
    trig_sel = 2'b00; lp_mode = 1'b0; ext_start = 1'b0;
    @(negedge clk);
    tmr_b_ovf = 1'b1; sw_start = 1'b1;
    @(negedge clk);
    tmr_b_ovf = 1'b0; sw_start = 1'b0;
    ext_start = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R4", busy, 0);
    trig_sel = 2'b01; tmr_a_ovf = 1'b1;
    @(negedge clk);
    tmr_a_ovf = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R4", busy, 0);

    // R5: sleep aborts a conversion
    trig_sel = 2'b10;
    fire(2'b10);
    repeat (4) @(negedge clk);
    sleep_req = 1'b1;
    chk(track_en == 1'b0, "R5", track_en, 0);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R5", busy, 0);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && track_en == 1'b0, "R5", busy, 0);
    sleep_req = 1'b0;
    @(negedge clk);
    chk(track_en == 1'b1, "R10", track_en, 1);
    lp_mode = 1'b1;
    @(negedge clk);
    chk(track_en == 1'b0, "R10", track_en, 0);

    // R8 / R9: random sources, modes, stalls and stray starts
    for (int k = 0; k < 24; k++)
      convert(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b1,
              $urandom_range(25, 100));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule